// File: doc/BRIEF.md
# Byte-Lane Parity Unit

This unit sits in the data path of a 36-bit FIFO. The FIFO word is made of four 9-bit byte lanes. A 3-bit program code sets how parity is handled. The code is captured from the low bits of the first word written after reset.

In a generate mode, the unit rewrites the top bit of each lane on the write side. That bit becomes even or odd parity over the lane's eight data bits, and the word then goes to storage. In a check mode, the unit tests each complete 9-bit lane on the read side as the word enters the output register. A lane that breaks the selected parity shows a low level in its top bit. With parity disabled, words cross both paths unchanged.

The write path and the read path each end in a register. The stored word appears one cycle after its write strobe. The output word changes only on a cycle with a read strobe.

Top module: `lane_parity_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `st_valid` goes to 0, `rd_data` clears to zero and the program code returns to 000 (disabled).
- R2: The first write after reset loads the program code from `wr_data[2:0]`. That word itself is stored unchanged, because the code in force during that write is still 000.
- R3: After it is loaded, the program code keeps its value through later writes until the next reset.
- R4: Any code with bit 2 at 0 (000 to 011) disables parity. Write words and read words then pass through bit for bit.
- R5: Code 100 (generate even): for each lane k, bit 9k+8 of the stored word equals the XOR of bits 9k to 9k+7. All other bits pass unchanged.
- R6: Code 101 (generate odd): for each lane k, bit 9k+8 of the stored word equals the inverted XOR of bits 9k to 9k+7. All other bits pass unchanged.
- R7: Code 110 (check even): for each lane k, bit 9k+8 of `rd_data` is low when bits 9k to 9k+8 of `rd_raw` hold an odd number of ones, and high otherwise. The data bits pass unchanged.
- R8: Code 111 (check odd): for each lane k, bit 9k+8 of `rd_data` is low when that 9-bit lane of `rd_raw` holds an even number of ones, and high otherwise. The data bits pass unchanged.
- R9: Generate codes leave the read path unchanged. Check codes leave the write path unchanged.
- R10: `st_valid` and `st_data` reflect the write strobe and word of the previous cycle. `rd_data` loads only on a cycle with `rd_en` high and holds otherwise.
- R11: A reset issued after a code has been loaded allows a different code to be loaded by the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Word written toward storage |
| st_valid | output | 1 | Registered write strobe toward storage |
| st_data | output | 36 | Registered word toward storage, parity applied |
| rd_en | input | 1 | Read strobe; loads the output register |
| rd_raw | input | 36 | Word read from storage |
| rd_data | output | 36 | Output register, with error bits in check modes |

## Verification
The hardest state to reach from the ports is a check mode combined with a read word whose lanes disagree with their stored parity. Each mode can only be entered through a reset followed by a first write, so a generate-mode run cannot move into a check mode without a fresh reset. The stimulus therefore resets before every table row and programs the row's code with a first write. It then applies read words whose four lanes deliberately mix correct and broken parity, so that the per-lane error bits differ within one word. Directed tests show that a later write carrying a different code leaves the program unchanged, and that a second reset allows a different code to be loaded.

// File: rtl/lanepar_pkg.sv
package lanepar_pkg;
  localparam int PROG_W = 3;

  typedef enum logic [PROG_W-1:0] {
    PM_OFF      = 3'b000,
    PM_GEN_EVEN = 3'b100,
    PM_GEN_ODD  = 3'b101,
    PM_CHK_EVEN = 3'b110,
    PM_CHK_ODD  = 3'b111
  } pmode_e;
endpackage

// File: rtl/lpu_prog_reg.sv
module lpu_prog_reg
  import lanepar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PROG_W-1:0] code_in,
  output logic [PROG_W-1:0] mode,
  output logic              loaded
);
  logic [PROG_W-1:0] mode_q;
  logic              loaded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_OFF;
      loaded_q <= 1'b0;
    end else if (wr_en && !loaded_q) begin
      mode_q   <= code_in;
      loaded_q <= 1'b1;
    end
  end

  assign mode   = mode_q;
  assign loaded = loaded_q;
endmodule

// File: rtl/lpu_lane_gen.sv
module lpu_lane_gen
  import lanepar_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic [PROG_W-1:0] mode,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int PB = LANE_W - 1;

  always_comb begin
    dout = din;
    if (mode == PM_GEN_EVEN)     dout[PB] = ^din[PB-1:0];
    else if (mode == PM_GEN_ODD) dout[PB] = ~(^din[PB-1:0]);
  end
endmodule

// File: rtl/lpu_lane_chk.sv
module lpu_lane_chk
  import lanepar_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic [PROG_W-1:0] mode,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int PB = LANE_W - 1;

  // A low top bit flags a lane error; a high top bit means the lane is good.
  always_comb begin
    dout = din;
    if (mode == PM_CHK_EVEN)     dout[PB] = ~(^din);
    else if (mode == PM_CHK_ODD) dout[PB] = ^din;
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lanepar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic                      st_valid,
  output logic [LANES*LANE_W-1:0]   st_data,
  input  logic                      rd_en,
  input  logic [LANES*LANE_W-1:0]   rd_raw,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  localparam int DATA_W = LANES * LANE_W;

  logic [PROG_W-1:0] prog_mode;
  logic              prog_loaded;
  logic [DATA_W-1:0] wr_proc;
  logic [DATA_W-1:0] rd_proc;
  logic [DATA_W-1:0] st_data_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              st_valid_q;

  lpu_prog_reg prog_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .code_in (wr_data[PROG_W-1:0]),
    .mode    (prog_mode),
    .loaded  (prog_loaded)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lpu_lane_gen #(.LANE_W(LANE_W)) gen_i (
      .mode (prog_mode),
      .din  (wr_data[k*LANE_W +: LANE_W]),
      .dout (wr_proc[k*LANE_W +: LANE_W])
    );
    lpu_lane_chk #(.LANE_W(LANE_W)) chk_i (
      .mode (prog_mode),
      .din  (rd_raw[k*LANE_W +: LANE_W]),
      .dout (rd_proc[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid_q <= 1'b0;
      st_data_q  <= '0;
      rd_data_q  <= '0;
    end else begin
      st_valid_q <= wr_en;
      if (wr_en) st_data_q <= wr_proc;
      if (rd_en) rd_data_q <= rd_proc;
    end
  end

  assign st_valid = st_valid_q;
  assign st_data  = st_data_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker
  import lanepar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [LANES*LANE_W-1:0] wr_data,
  input logic                    st_valid,
  input logic [LANES*LANE_W-1:0] st_data,
  input logic                    rd_en,
  input logic [LANES*LANE_W-1:0] rd_raw,
  input logic [LANES*LANE_W-1:0] rd_data,
  input logic [PROG_W-1:0]       prog_mode,
  input logic                    prog_loaded
);
  localparam int PB = LANE_W - 1;

  assert_first_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !prog_loaded) |=> (prog_mode == $past(wr_data[PROG_W-1:0])));

  assert_code_holds_R3: assert property (@(posedge clk) disable iff (rst)
    prog_loaded |=> $stable(prog_mode));

  assert_off_passthrough_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !prog_mode[2]) |=> (st_data == $past(wr_data)));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> st_valid);

  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !st_valid);

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    assert_gen_even_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && prog_mode == PM_GEN_EVEN) |=>
        (st_data[k*LANE_W+PB] == ^st_data[k*LANE_W +: PB]));

    assert_gen_odd_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && prog_mode == PM_GEN_ODD) |=>
        (st_data[k*LANE_W+PB] == ~(^st_data[k*LANE_W +: PB])));

    assert_chk_even_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && prog_mode == PM_CHK_EVEN) |=>
        (rd_data[k*LANE_W+PB] == ~(^$past(rd_raw[k*LANE_W +: LANE_W]))));

    assert_chk_odd_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_en && prog_mode == PM_CHK_ODD) |=>
        (rd_data[k*LANE_W+PB] == ^$past(rd_raw[k*LANE_W +: LANE_W])));
  end
endmodule

bind lane_parity_unit lpu_checker #(.LANES(LANES), .LANE_W(LANE_W)) chk_bind_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .st_valid    (st_valid),
  .st_data     (st_data),
  .rd_en       (rd_en),
  .rd_raw      (rd_raw),
  .rd_data     (rd_data),
  .prog_mode   (prog_mode),
  .prog_loaded (prog_loaded)
);

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int NVEC = 8;

  localparam logic [2:0] V_MODE [NVEC] = '{
    3'b000, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111, 3'b100, 3'b111};
  localparam logic [DW-1:0] V_WR [NVEC] = '{
    36'hF_FFFF_FFFF, 36'h1_2345_6789, 36'h0_0000_0000, 36'h0_0000_0000,
    36'hA_5A5A_5A5A, 36'h3_C3C3_C3C3, 36'h7_0F1E_2D3C, 36'hE_DCBA_9876};
  localparam logic [DW-1:0] V_RD [NVEC] = '{
    36'h9_8765_4321, 36'h0_0F0F_0F0F, 36'h5_5555_5555, 36'hF_0F0F_0F0F,
    36'h0_0000_0101, 36'h1_0020_0403, 36'h8_0402_01FF, 36'h0_0000_0000};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          st_valid;
  logic [DW-1:0] st_data;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_raw = '0;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_parity_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .st_valid(st_valid), .st_data(st_data),
    .rd_en(rd_en), .rd_raw(rd_raw), .rd_data(rd_data)
  );

  // Expected word from the requirements: write side applies generate codes,
  // read side applies check codes, all else passes.
  function automatic logic [DW-1:0] model(input logic [2:0] m,
                                          input logic [DW-1:0] d,
                                          input bit wr_side);
    logic [DW-1:0] r;
    logic [8:0]    lane;
    r = d;
    for (int k = 0; k < 4; k++) begin
      lane = d[k*9 +: 9];
      if (m[2] && wr_side && !m[1])
        r[k*9+8] = m[0] ? ~(^lane[7:0]) : ^lane[7:0];
      if (m[2] && !wr_side && m[1])
        r[k*9+8] = m[0] ? ^lane : ~(^lane);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_raw = d;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    check("R1 st_valid after reset", {35'd0, st_valid}, '0);
    check("R1 rd_data after reset", rd_data, '0);

    // Table walk: reset, program, write, read
    for (int i = 0; i < NVEC; i++) begin
      logic [DW-1:0] prog_word;
      prog_word = {V_WR[i][DW-1:3], V_MODE[i]};
      do_reset();
      do_write(prog_word);
      check("R2 program word stored unchanged", st_data, prog_word);
      do_write(V_WR[i]);
      check("R4/R5/R6/R9 write path", st_data, model(V_MODE[i], V_WR[i], 1'b1));
      do_read(V_RD[i]);
      check("R4/R7/R8/R9 read path", rd_data, model(V_MODE[i], V_RD[i], 1'b0));
    end

    // R3: a later write with code bits 110 must not change generate-even
    do_reset();
    do_write(36'h0_0000_0004);
    do_write(36'h0_0000_0006);
    do_write(36'h0_0000_0001);
    check("R3 code held after later write", st_data,
          model(3'b100, 36'h0_0000_0001, 1'b1));
    do_read(36'h0_0000_0001);
    check("R3 read path still passthrough", rd_data, 36'h0_0000_0001);

    // R10: valid timing and read hold
    check("R10 st_valid drops after idle", {35'd0, st_valid}, '0);
    @(negedge clk); rd_raw = 36'hF_FFFF_FFFF;
    @(negedge clk);
    check("R10 rd_data holds without rd_en", rd_data, 36'h0_0000_0001);
    @(negedge clk); wr_en = 1'b1; wr_data = 36'h0_0000_0003;
    @(negedge clk);
    check("R10 st_valid one cycle after strobe", {35'd0, st_valid}, 36'd1);
    wr_en = 1'b0;

    // R11: reset clears the code; a new code (disabled) is loaded
    do_reset();
    check("R1 rd_data cleared by later reset", rd_data, '0);
    do_write(36'h0_0000_0000);
    do_write(36'h0_0000_0101);
    check("R11 new disabled code after reset", st_data, 36'h0_0000_0101);
    do_read(36'h0_0000_0101);
    check("R11 read passthrough after reprogram", rd_data, 36'h0_0000_0101);

    // R8: check-odd with a mix of good and bad lanes
    do_reset();
    do_write(36'h0_0000_0007);
    do_read(36'h0_0402_01FF);
    check("R8 mixed lane errors", rd_data, model(3'b111, 36'h0_0402_01FF, 1'b0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule